// File: doc/BRIEF.md
# Drive Command Decoder and State

This block sits behind the serial command receiver of a disk drive. Each cycle that `cmd_valid_i` is high, it takes one 16-bit command word that has already passed its parity check. The upper four bits pick a function and the lower twelve bits carry either a modifier (bits 11-8) or a parameter. A legal command updates the drive state the block holds: the target cylinder, the head group, two offset settings (read strobe and track), the spindle run state, and the status word with its attention summary.

Commands that return data do not send it themselves. They raise a one-cycle response request, together with a flag that picks status or configuration data, and a separate serializer handles the transfer. Arm motion is not modelled. A seek or recalibrate sets a busy bit, and the `seek_done_i` input, which stands in for the fixed mechanical latency, clears it. A command is illegal if it uses a reserved function code, a reserved modifier, or a nonzero bit in a field that does not apply to it. An illegal command changes no state except an invalid-command fault bit, and that bit raises attention.

Every state update lands on the clock edge that samples the command, so outputs show the new value one cycle after `cmd_valid_i`.

Top module: `drv_cmd_core`

## Requirements
- R1: After reset the target cylinder, head group, both offsets, fault bits, busy bit, attention and response request are all zero, and the spindle bit equals parameter SPIN_AT_RST.
- R2: Function 0 (seek) loads the target cylinder from bits 11-0 and sets status bit 12 (busy). Busy clears on the edge after `seek_done_i` is high, unless a seek or recalibrate arrives on that same edge.
- R3: Function 1 (recalibrate) requires bits 11-0 to be zero. It sets the target cylinder to 0 and sets busy.
- R4: A legal seek or recalibrate resets both the strobe offset and the track offset to 3'b000.
- R5: Function 6 sets the strobe offset and function 7 sets the track offset. Both require bits 7-0 zero and modifier bit 11 zero. The 3-bit offset output is {direction, magnitude[1:0]}. The magnitude is modifier bits 10-9. The direction is modifier bit 8 (1 = late/reverse) when the magnitude is nonzero, and 0 otherwise. The two offsets are held independently.
- R6: Function 5 (control) requires bits 7-0 zero. Modifier 0000 clears status bits 11-0, modifier 0010 stops the spindle (status bit 13 = 0), modifier 0011 starts it. Any other modifier is illegal.
- R7: Function 4 takes the head group from bits 7-4 and requires bits 11-8 and 3-0 to be zero. `head_num_o` equals group × 16 + `head_sel_i`.
- R8: Function 2 (status request, bits 11-0 zero) and function 3 (configuration request, bits 7-0 zero) each give a one-cycle `resp_req_o`. `resp_cfg_o` is 0 for function 2 and 1 for function 3.
- R9: Function 8 (diagnostics, bits 11-0 zero) and function 9 (sector size, any parameter) are legal and change no output.
- R10: Functions 10-15, reserved modifiers and nonzero inapplicable bits make a command illegal. An illegal command sets status bit 0, changes no other state and gives no response request.
- R11: `fault_set_i` bit n sets status bit n (n = 0..11). A set in the same cycle as a clear wins. `attn_o` is high exactly when any of status bits 11-0 is set. Bits 12 (busy) and 13 (spindle) never raise it, and bits 15-14 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word present this cycle |
| cmd_word_i | input | 16 | Parity-checked command word |
| head_sel_i | input | 4 | Low head number from the select lines |
| seek_done_i | input | 1 | Arm settled, clears busy |
| fault_set_i | input | 12 | Fault events to latch into status bits 11-0 |
| target_cyl_o | output | 12 | Target cylinder |
| head_group_o | output | 4 | Selected head group |
| head_num_o | output | 8 | Absolute head number |
| strobe_ofs_o | output | 3 | Strobe offset {direction, magnitude} |
| track_ofs_o | output | 3 | Track offset {direction, magnitude} |
| spindle_on_o | output | 1 | Spindle run state |
| status_o | output | 16 | Status word |
| attn_o | output | 1 | Attention |
| resp_req_o | output | 1 | One-cycle response request |
| resp_cfg_o | output | 1 | Response kind: 1 configuration, 0 status |

## Verification
The bench builds the block with SPIN_AT_RST = 1. The spindle therefore comes out of reset running, and the very first stop command gives a visible change on status bit 13 and `spindle_on_o`, not a write of the value already held. With the spindle bit high from reset, the attention check also confirms that a state bit does not leak into `attn_o`. A random mix of legal and corrupted words, run alongside concurrent fault events and seek completions, reaches the priority cases: a set colliding with a clear, and busy meeting a new seek on the same edge.

// File: rtl/drv_cmd_pkg.sv
package drv_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int FUNC_W  = 4;
  localparam int ARG_W   = WORD_W - FUNC_W;
  localparam int MOD_W   = 4;
  localparam int GRP_W   = 4;
  localparam int HSEL_W  = 4;
  localparam int HEAD_W  = GRP_W + HSEL_W;
  localparam int FAULT_W = 12;
  localparam int STAT_W  = 16;
  localparam int OFS_N   = 2;

  typedef enum logic [FUNC_W-1:0] {
    OP_SEEK    = 4'd0,
    OP_RECAL   = 4'd1,
    OP_RQ_STAT = 4'd2,
    OP_RQ_CFG  = 4'd3,
    OP_HGRP    = 4'd4,
    OP_CTRL    = 4'd5,
    OP_STROBE  = 4'd6,
    OP_TRACK   = 4'd7,
    OP_DIAG    = 4'd8,
    OP_BPS     = 4'd9
  } op_e;

  typedef struct packed {
    logic       late;
    logic [1:0] mag;
  } ofs_t;

  function automatic ofs_t ofs_from_mod(input logic [MOD_W-1:0] m);
    ofs_t o;
    o.mag  = m[2:1];
    o.late = (m[2:1] != 2'b00) & m[0];
    return o;
  endfunction
endpackage

// File: rtl/drv_cmd_decode.sv
module drv_cmd_decode
  import drv_cmd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [FUNC_W-1:0] op_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic              ok_o
);
  logic [MOD_W-1:0] mod;
  logic             lo_zero, all_zero;

  assign op_o     = word_i[WORD_W-1 -: FUNC_W];
  assign arg_o    = word_i[ARG_W-1:0];
  assign mod      = word_i[ARG_W-1 -: MOD_W];
  assign lo_zero  = (word_i[7:0] == 8'h00);
  assign all_zero = lo_zero && (mod == '0);

  always_comb begin
    unique case (op_o)
      OP_SEEK:    ok_o = 1'b1;
      OP_RECAL:   ok_o = all_zero;
      OP_RQ_STAT: ok_o = all_zero;
      OP_RQ_CFG:  ok_o = lo_zero;
      OP_HGRP:    ok_o = (mod == '0) && (word_i[3:0] == 4'h0);
      OP_CTRL:    ok_o = lo_zero && (mod == 4'd0 || mod == 4'd2 || mod == 4'd3);
      OP_STROBE,
      OP_TRACK:   ok_o = lo_zero && !mod[MOD_W-1];
      OP_DIAG:    ok_o = all_zero;
      OP_BPS:     ok_o = 1'b1;
      default:    ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/drv_ofs_reg.sv
module drv_ofs_reg
  import drv_cmd_pkg::*;
#(
  parameter logic [FUNC_W-1:0] OPC = OP_STROBE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [FUNC_W-1:0] op_i,
  input  logic [MOD_W-1:0]  mod_i,
  output ofs_t              ofs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ofs_o <= '0;
    else if (fire_i) begin
      if (op_i == OPC) ofs_o <= ofs_from_mod(mod_i);
      else if (op_i == OP_SEEK || op_i == OP_RECAL) ofs_o <= '0;
    end
  end
endmodule

// File: rtl/drv_stat_reg.sv
module drv_stat_reg
  import drv_cmd_pkg::*;
#(
  parameter bit SPIN_AT_RST = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               bad_i,
  input  logic [FUNC_W-1:0]  op_i,
  input  logic [MOD_W-1:0]   mod_i,
  input  logic [FAULT_W-1:0] fault_set_i,
  input  logic               seek_done_i,
  output logic [STAT_W-1:0]  status_o
);
  logic [FAULT_W-1:0] flt_q;
  logic               busy_q, spin_q, ctrl, clr;

  assign ctrl = fire_i && (op_i == OP_CTRL);
  assign clr  = ctrl && (mod_i == 4'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q  <= '0;
      busy_q <= 1'b0;
      spin_q <= SPIN_AT_RST;
    end else begin
      // set beats clear
      flt_q <= (clr ? '0 : flt_q) | fault_set_i | {{(FAULT_W-1){1'b0}}, bad_i};
      if (fire_i && (op_i == OP_SEEK || op_i == OP_RECAL)) busy_q <= 1'b1;
      else if (seek_done_i) busy_q <= 1'b0;
      if (ctrl && mod_i == 4'd2) spin_q <= 1'b0;
      else if (ctrl && mod_i == 4'd3) spin_q <= 1'b1;
    end
  end

  assign status_o = {2'b00, spin_q, busy_q, flt_q};
endmodule

// File: rtl/drv_cmd_core.sv
module drv_cmd_core
  import drv_cmd_pkg::*;
#(
  parameter bit SPIN_AT_RST = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [WORD_W-1:0]  cmd_word_i,
  input  logic [HSEL_W-1:0]  head_sel_i,
  input  logic               seek_done_i,
  input  logic [FAULT_W-1:0] fault_set_i,
  output logic [ARG_W-1:0]   target_cyl_o,
  output logic [GRP_W-1:0]   head_group_o,
  output logic [HEAD_W-1:0]  head_num_o,
  output logic [2:0]         strobe_ofs_o,
  output logic [2:0]         track_ofs_o,
  output logic               spindle_on_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               attn_o,
  output logic               resp_req_o,
  output logic               resp_cfg_o
);
  logic [FUNC_W-1:0] op;
  logic [ARG_W-1:0]  arg;
  logic              cmd_ok, fire, bad;
  logic [MOD_W-1:0]  mod;
  ofs_t              ofs_q [OFS_N];

  drv_cmd_decode u_dec (.word_i(cmd_word_i), .op_o(op), .arg_o(arg), .ok_o(cmd_ok));

  assign fire = cmd_valid_i && cmd_ok;
  assign bad  = cmd_valid_i && !cmd_ok;
  assign mod  = arg[ARG_W-1 -: MOD_W];

  for (genvar g = 0; g < OFS_N; g++) begin : g_ofs
    localparam logic [FUNC_W-1:0] OPC = (g == 0) ? OP_STROBE : OP_TRACK;
    drv_ofs_reg #(.OPC(OPC)) u_ofs (
      .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire),
      .op_i(op), .mod_i(mod), .ofs_o(ofs_q[g])
    );
  end

  drv_stat_reg #(.SPIN_AT_RST(SPIN_AT_RST)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .bad_i(bad),
    .op_i(op), .mod_i(mod), .fault_set_i(fault_set_i),
    .seek_done_i(seek_done_i), .status_o(status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_cyl_o <= '0;
      head_group_o <= '0;
      resp_req_o   <= 1'b0;
      resp_cfg_o   <= 1'b0;
    end else begin
      if (fire && op == OP_SEEK)  target_cyl_o <= arg;
      if (fire && op == OP_RECAL) target_cyl_o <= '0;
      if (fire && op == OP_HGRP)  head_group_o <= arg[4 +: GRP_W];
      resp_req_o <= fire && (op == OP_RQ_STAT || op == OP_RQ_CFG);
      resp_cfg_o <= fire && (op == OP_RQ_CFG);
    end
  end

  assign head_num_o   = {head_group_o, head_sel_i};
  assign strobe_ofs_o = ofs_q[0];
  assign track_ofs_o  = ofs_q[1];
  assign spindle_on_o = status_o[13];
  assign attn_o       = |status_o[FAULT_W-1:0];
endmodule

// File: rtl/drv_cmd_chk.sv
module drv_cmd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [15:0] cmd_word_i,
  input logic        cmd_ok,
  input logic        seek_done_i,
  input logic [11:0] fault_set_i,
  input logic [11:0] target_cyl_o,
  input logic [2:0]  strobe_ofs_o,
  input logic [2:0]  track_ofs_o,
  input logic [15:0] status_o,
  input logic        attn_o,
  input logic        resp_req_o
);
  // R10
  inv_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_ok |=> status_o[0]);

  // R10
  inv_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_ok |=> $stable(target_cyl_o) && $stable(strobe_ofs_o)
                               && $stable(track_ofs_o) && !resp_req_o);

  // R4
  ofs_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ok && cmd_word_i[15:13] == 3'b000
    |=> strobe_ofs_o == 3'b000 && track_ofs_o == 3'b000);

  // R6
  clr_attn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_word_i == 16'h5000 && fault_set_i == 12'h000 |=> !attn_o);

  // R2
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[12]) |-> $past(seek_done_i));

  // R8
  resp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_req_o) |-> $past(cmd_valid_i && cmd_ok));
endmodule

bind drv_cmd_core drv_cmd_chk u_chk (.*);

// File: tb/tb_drv_cmd_core.sv
`timescale 1ns/1ps
module tb_drv_cmd_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [15:0] w = '0;
  logic [3:0]  hs = '0;
  logic        done = 1'b0;
  logic [11:0] fs = '0;
  logic [11:0] cyl;
  logic [3:0]  grp;
  logic [7:0]  hnum;
  logic [2:0]  sofs, tofs;
  logic        spin, attn, rreq, rcfg;
  logic [15:0] stat;

  int total = 0;
  int bad = 0;

  // model state
  logic [11:0] m_cyl;
  logic [3:0]  m_grp;
  logic [2:0]  m_sofs, m_tofs;
  logic        m_spin, m_busy, m_req, m_cfg;
  logic [11:0] m_flt;

  always #2.5 clk = ~clk;

  drv_cmd_core #(.SPIN_AT_RST(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(v), .cmd_word_i(w),
    .head_sel_i(hs), .seek_done_i(done), .fault_set_i(fs),
    .target_cyl_o(cyl), .head_group_o(grp), .head_num_o(hnum),
    .strobe_ofs_o(sofs), .track_ofs_o(tofs), .spindle_on_o(spin),
    .status_o(stat), .attn_o(attn), .resp_req_o(rreq), .resp_cfg_o(rcfg)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic bit legal(input logic [15:0] x);
    logic [3:0] m;
    m = x[11:8];
    case (x[15:12])
      4'd0, 4'd9: return 1'b1;
      4'd1, 4'd2, 4'd8: return x[11:0] == 12'h000;
      4'd3: return x[7:0] == 8'h00;
      4'd4: return m == 4'd0 && x[3:0] == 4'd0;
      4'd5: return x[7:0] == 8'h00 && (m == 4'd0 || m == 4'd2 || m == 4'd3);
      4'd6, 4'd7: return x[7:0] == 8'h00 && !m[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [15:0] x);
    if (!legal(x)) return "R10";
    case (x[15:12])
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R8";
      4'd4: return "R7";
      4'd5: return "R6";
      4'd6, 4'd7: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [2:0] enc(input logic [3:0] m);
    return {(m[2:1] != 2'b00) & m[0], m[2:1]};
  endfunction

  task automatic model_reset();
    m_cyl = '0; m_grp = '0; m_sofs = '0; m_tofs = '0;
    m_spin = 1'b1; m_busy = 1'b0; m_flt = '0; m_req = 1'b0; m_cfg = 1'b0;
  endtask

  task automatic compare(input string tag);
    check(tag, "cyl", 32'(cyl), 32'(m_cyl));
    check(tag, "grp", 32'(grp), 32'(m_grp));
    check(tag, "hnum", 32'(hnum), 32'({m_grp, hs}));
    check(tag, "sofs", 32'(sofs), 32'(m_sofs));
    check(tag, "tofs", 32'(tofs), 32'(m_tofs));
    check(tag, "spin", 32'(spin), 32'(m_spin));
    check(tag, "stat", 32'(stat), 32'({2'b00, m_spin, m_busy, m_flt}));
    check(tag, "attn", 32'(attn), 32'(m_flt != 12'h000));
    check(tag, "req", 32'(rreq), 32'(m_req));
    check(tag, "cfg", 32'(rcfg), 32'(m_cfg));
  endtask

  // called at negedge; applies one cycle and checks after the edge
  task automatic step(input logic vv, input logic [15:0] ww, input logic [11:0] ff,
                      input logic dd, input string tag);
    logic ok, fire;
    logic [3:0] op, m;
    v = vv; w = ww; fs = ff; done = dd;
    ok = legal(ww); fire = vv & ok; op = ww[15:12]; m = ww[11:8];
    m_flt = ((fire && op == 4'd5 && m == 4'd0) ? 12'h000 : m_flt) | ff | {11'b0, vv & !ok};
    if (fire && (op == 4'd0 || op == 4'd1)) m_busy = 1'b1;
    else if (dd) m_busy = 1'b0;
    if (fire && op == 4'd5 && m == 4'd2) m_spin = 1'b0;
    if (fire && op == 4'd5 && m == 4'd3) m_spin = 1'b1;
    if (fire && op == 4'd0) m_cyl = ww[11:0];
    if (fire && op == 4'd1) m_cyl = '0;
    if (fire && op == 4'd4) m_grp = ww[7:4];
    if (fire && (op == 4'd0 || op == 4'd1)) begin m_sofs = '0; m_tofs = '0; end
    if (fire && op == 4'd6) m_sofs = enc(m);
    if (fire && op == 4'd7) m_tofs = enc(m);
    m_req = fire && (op == 4'd2 || op == 4'd3);
    m_cfg = fire && op == 4'd3;
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
    v = 1'b0; fs = '0; done = 1'b0;
  endtask

  task automatic cmd(input logic [15:0] ww, input string tag);
    step(1'b1, ww, 12'h000, 1'b0, tag);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rw;
    void'($urandom(32'd7341));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    cmd(16'h0ABC, "R2");                         // seek, busy set
    step(1'b0, 16'h0000, 12'h000, 1'b1, "R2");  // done clears busy
    cmd(16'h6300, "R5");                         // strobe late 1 -> 101
    cmd(16'h7400, "R5");                         // track mag 2 -> 010
    cmd(16'h6100, "R5");                         // strobe back to 000
    cmd(16'h6700, "R5");
    cmd(16'h0FFF, "R4");                         // seek clears both offsets
    cmd(16'h6500, "R5");
    cmd(16'h7300, "R5");
    cmd(16'h1000, "R4");                         // recal: cyl 0, offsets 0
    step(1'b1, 16'h0123, 12'h000, 1'b1, "R2");  // new seek wins over done
    cmd(16'h1001, "R3");                         // recal with stray bit: illegal
    cmd(16'hA000, "R10");
    cmd(16'h6800, "R10");
    cmd(16'h5100, "R10");
    cmd(16'h4130, "R10");
    cmd(16'h5000, "R6");                         // clear faults
    cmd(16'h5200, "R6");                         // stop spindle
    cmd(16'h5300, "R6");
    step(1'b0, 16'h0000, 12'h800, 1'b0, "R11");
    step(1'b1, 16'h5000, 12'h010, 1'b0, "R11"); // set beats clear
    cmd(16'h5000, "R11");
    hs = 4'h5;
    cmd(16'h4030, "R7");
    hs = 4'hA;
    cmd(16'h40F0, "R7");
    cmd(16'h2000, "R8");
    cmd(16'h3500, "R8");
    cmd(16'h2010, "R10");
    cmd(16'h8000, "R9");
    cmd(16'h9ABC, "R9");

    for (int i = 0; i < 600; i++) begin
      logic [11:0] f;
      logic d;
      rw = 16'($urandom);
      case ($urandom % 4)
        0: rw[7:0] = 8'h00;
        1: begin rw[7:0] = 8'h00; rw[11] = 1'b0; end
        2: rw[11:0] = ($urandom % 2) ? 12'h000 : {4'h0, rw[7:4], 4'h0};
        default: ;
      endcase
      hs = 4'($urandom);
      f = ($urandom % 8 == 0) ? 12'(1 << ($urandom % 12)) : 12'h000;
      d = ($urandom % 4 == 0);
      step(($urandom % 5) != 0, rw, f, d, req_of(rw));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule